// File: doc/BRIEF.md
# BCD Clock-Calendar Register File

This block keeps wall-clock time and calendar date in packed BCD: second, minute, hour (24-hour form), day of week, day of month, month and two-digit year. A synchronous one-cycle enable, asserted once per second, advances a set of live counters. Month lengths of 28, 29, 30 and 31 days are applied without software help, and February gets 29 days in leap years.

Software never reads the live counters directly. It sees eight bytes at the very top of a byte-wide address window: one control byte and seven clock bytes. The clock bytes are ordinary storage that is overwritten with the counter contents whenever the counters advance. The control byte lets software freeze those bytes so that it can read them without the fields changing in the middle of a read. It also lets software open them for writing and then move the written values into the counters in a single cycle. The same byte holds a per-minute trim setting that either swallows or inserts second steps.

Top module: `bcd_rtc_regs`

## Requirements
- R1: After reset the window reads control 00h, seconds 00h, minutes 00h, hours 00h, day of week 01h, date 01h, month 01h, year 00h.
- R2: The window is decoded only when every address bit above bit 2 is 1. Offset 0 is control, and offsets 1 to 7 are seconds, minutes, hours, day of week, date, month and year. A read returns the byte combinationally in the same cycle. Any address outside the window reads 00h and holds `bus_hit` low.
- R3: Each seconds step advances the seconds by one in BCD, and seconds 59h wraps to 00h. On that wrap the minutes step, minutes 59h wraps to 00h and steps the hours, and hours 23h wraps to 00h and steps the day. When control bits 7 and 6 are both clear, the clock bytes show the new values from the clock edge of the step.
- R4: On a day step the day of week goes 07h to 01h and otherwise increments. A date past the month's last day becomes 01h and steps the month. Month 12h becomes 01h and steps the year, and year 99h becomes 00h.
- R5: Months 04h, 06h, 09h and 11h have 30 days. February has 29 days when the year, read as a decimal number 0 to 99, is a multiple of 4, and 28 days otherwise. All other months have 31 days.
- R6: While control bit 6 is 1 (and bit 7 is 0), the clock bytes do not change, but the counters keep running. After bit 6 is cleared, the next step shows the counters' current time.
- R7: While control bit 7 is 1, the clock bytes are not refreshed and writes to offsets 1 to 7 are stored. Each write is masked per field: seconds and minutes 7Fh, hours 3Fh, day of week 07h, date 3Fh, month 1Fh, year FFh. While bit 7 is 0, writes to offsets 1 to 7 are ignored.
- R8: A write to control that has bit 7 at 0, while bit 7 is currently 1, copies the seven clock bytes into the counters. Counting resumes from those values.
- R9: A tick in the same cycle as that copy is discarded, so the counters hold exactly the copied values afterwards.
- R10: The control byte reads back all eight bits as last written.
- R11: With control bit 5 = 0 and magnitude M in bits 4:0, the first M ticks after a tick wraps the seconds to 00h do not step the time.
- R12: With control bit 5 = 1 and magnitude M, the M cycles without a tick that follow such a wrap each add one extra seconds step. Each extra step refreshes the clock bytes as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_sel | input | 1 | Byte access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| bus_hit | output | 1 | Address falls in the clock window |

## Verification
A tick can land in the same cycle as the control write that commits a loaded time. The bench provokes this by driving `sec_tick` high during that control write. It judges the result by reading the seconds byte right afterwards: the value must equal the one just written, and only the next tick may advance it. A second overlap is an extra trim step beside a minute wrap. The bench checks this by counting how far the seconds byte has moved a few idle cycles after the wrap, and again after the next real tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W = 8;
    localparam int OFF_W  = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hr;
        byte_t dow;
        byte_t date;
        byte_t mon;
        byte_t yr;
    } rtc_time_t;

    localparam rtc_time_t TIME_RST = '{sec: 8'h00, min: 8'h00, hr: 8'h00,
                                       dow: 8'h01, date: 8'h01, mon: 8'h01,
                                       yr: 8'h00};

    function automatic byte_t bcd_inc(input byte_t v);
        byte_t r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic is_leap(input byte_t y);
        logic [7:0] bin;
        bin = 8'(y[7:4]) * 8'd10 + 8'(y[3:0]);
        return bin[1:0] == 2'b00;
    endfunction

    function automatic byte_t last_day(input byte_t mon, input byte_t yr);
        byte_t r;
        case (mon)
            8'h02:                      r = is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

    function automatic byte_t field_mask(input logic [OFF_W-1:0] off);
        byte_t r;
        case (off)
            3'd1, 3'd2: r = 8'h7F;
            3'd3, 3'd5: r = 8'h3F;
            3'd4:       r = 8'h07;
            3'd6:       r = 8'h1F;
            default:    r = 8'hFF;
        endcase
        return r;
    endfunction

    function automatic byte_t get_field(input rtc_time_t t, input logic [OFF_W-1:0] off);
        byte_t r;
        case (off)
            3'd1:    r = t.sec;
            3'd2:    r = t.min;
            3'd3:    r = t.hr;
            3'd4:    r = t.dow;
            3'd5:    r = t.date;
            3'd6:    r = t.mon;
            3'd7:    r = t.yr;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic rtc_time_t put_field(input rtc_time_t t, input logic [OFF_W-1:0] off,
                                            input byte_t v);
        rtc_time_t r;
        r = t;
        case (off)
            3'd1:    r.sec  = v;
            3'd2:    r.min  = v;
            3'd3:    r.hr   = v;
            3'd4:    r.dow  = v;
            3'd5:    r.date = v;
            3'd6:    r.mon  = v;
            3'd7:    r.yr   = v;
            default: r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now,
    output rtc_time_t nxt,
    output logic      sec_wrap
);

    typedef struct packed {
        rtc_time_t t;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        sec_wrap = 1'b0;
        if (load) begin
            st_d.t = load_val;
        end else if (step) begin
            if (st_q.t.sec == 8'h59) begin
                st_d.t.sec = 8'h00;
                sec_wrap   = 1'b1;
                if (st_q.t.min == 8'h59) begin
                    st_d.t.min = 8'h00;
                    if (st_q.t.hr == 8'h23) begin
                        st_d.t.hr  = 8'h00;
                        st_d.t.dow = (st_q.t.dow >= 8'h07) ? 8'h01 : bcd_inc(st_q.t.dow);
                        if (st_q.t.date >= last_day(st_q.t.mon, st_q.t.yr)) begin
                            st_d.t.date = 8'h01;
                            if (st_q.t.mon >= 8'h12) begin
                                st_d.t.mon = 8'h01;
                                st_d.t.yr  = (st_q.t.yr == 8'h99) ? 8'h00 : bcd_inc(st_q.t.yr);
                            end else begin
                                st_d.t.mon = bcd_inc(st_q.t.mon);
                            end
                        end else begin
                            st_d.t.date = bcd_inc(st_q.t.date);
                        end
                    end else begin
                        st_d.t.hr = bcd_inc(st_q.t.hr);
                    end
                end else begin
                    st_d.t.min = bcd_inc(st_q.t.min);
                end
            end else begin
                st_d.t.sec = bcd_inc(st_q.t.sec);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{t: TIME_RST};
        else        st_q <= st_d;
    end

    assign now = st_q.t;
    assign nxt = st_d.t;

    // R3: without a step or a load the counters hold
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(now));

    // R3: a step always moves the seconds
    p_sec_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (now.sec != $past(now.sec)));

    // R4: end of day clears the time of day and moves the weekday
    p_day_roll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && now.sec == 8'h59 && now.min == 8'h59 && now.hr == 8'h23)
        |=> (now.hr == 8'h00 && now.min == 8'h00 && now.sec == 8'h00
             && now.dow != $past(now.dow)));

endmodule

// File: rtl/rtc_trim.sv
module rtc_trim #(
    parameter int MAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic             speed_up,
    input  logic [MAG_W-1:0] mag,
    input  logic             wrap,
    output logic             step
);

    typedef struct packed {
        logic [MAG_W-1:0] left;
    } trim_st_t;

    trim_st_t st_d, st_q;
    logic     active;
    logic     consume;

    always_comb begin
        st_d    = st_q;
        active  = (st_q.left != '0);
        consume = active && (tick ? !speed_up : speed_up);
        step    = !clear && (tick ? !(active && !speed_up) : (active && speed_up));
        if (clear)                st_d.left = '0;
        else if (wrap && !active) st_d.left = mag;
        else if (consume)         st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a wrap with no pending trim arms the budget from the magnitude
    p_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !active && !clear) |=> (st_q.left == $past(mag)));

    // R12: an armed budget never grows until the next wrap
    p_budget_down_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clear) |=> (st_q.left <= $past(st_q.left)));

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_hit
);

    localparam int MAG_W    = 5;
    localparam int BIT_WREQ = 7;
    localparam int BIT_HOLD = 6;
    localparam int BIT_SIGN = MAG_W;

    typedef struct packed {
        byte_t     ctrl;
        rtc_time_t vis;
    } regs_t;

    regs_t            r_d, r_q;
    logic [OFF_W-1:0] off;
    logic             wr_en;
    logic             load;
    logic             step;
    logic             wrap;
    rtc_time_t        now;
    rtc_time_t        nxt;

    assign bus_hit = &bus_addr[ADDR_W-1:OFF_W];
    assign off     = bus_addr[OFF_W-1:0];
    assign wr_en   = bus_sel && bus_wr && bus_hit;
    assign load    = wr_en && (off == '0) && r_q.ctrl[BIT_WREQ] && !bus_wdata[BIT_WREQ];

    rtc_trim #(.MAG_W(MAG_W)) u_trim (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .clear    (load),
        .speed_up (r_q.ctrl[BIT_SIGN]),
        .mag      (r_q.ctrl[MAG_W-1:0]),
        .wrap     (wrap),
        .step     (step)
    );

    rtc_time_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (load),
        .load_val (r_q.vis),
        .now      (now),
        .nxt      (nxt),
        .sec_wrap (wrap)
    );

    always_comb begin
        r_d = r_q;
        if (step && !r_q.ctrl[BIT_WREQ] && !r_q.ctrl[BIT_HOLD]) r_d.vis = nxt;
        if (wr_en) begin
            if (off == '0)                r_d.ctrl = bus_wdata;
            else if (r_q.ctrl[BIT_WREQ])  r_d.vis  = put_field(r_q.vis, off, bus_wdata & field_mask(off));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{ctrl: 8'h00, vis: TIME_RST};
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && bus_hit)
            bus_rdata = (off == '0) ? r_q.ctrl : get_field(r_q.vis, off);
    end

    // R6: hold freezes the visible bytes
    p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctrl[BIT_HOLD] && !r_q.ctrl[BIT_WREQ]) |=> $stable(r_q.vis));

    // R7: clock-byte writes without the write request change nothing
    p_wr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off != '0 && !r_q.ctrl[BIT_WREQ] && !step) |=> $stable(r_q.vis));

    // R8: after a commit the counters equal the visible bytes
    p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (now == r_q.vis));

    // R9: no step is taken in the commit cycle
    p_commit_nostep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !step);

endmodule

// File: tb/sim_bcd_rtc_regs.sv
`timescale 1ns/1ps
module sim_bcd_rtc_regs;

    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       sample_ev;

    always #4 clk = ~clk;

    bcd_rtc_regs #(.ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (tick),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .bus_hit   (hit)
    );

    // monitor: pops one expectation per sample event
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rdata !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    function automatic logic [AW-1:0] win(input logic [2:0] o);
        return {{(AW-3){1'b1}}, o};
    endfunction

    task automatic cyc(input bit s, input bit w, input logic [2:0] o, input logic [7:0] d, input bit t);
        @(negedge clk);
        sel = s; wr = w; addr = win(o); wdata = d; tick = t;
        @(posedge clk);
        #1;
        sel = 1'b0; wr = 1'b0; tick = 1'b0;
    endtask

    task automatic rd_raw(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a; tick = 1'b0;
        #2;
        -> sample_ev;
        @(posedge clk);
        #1;
        sel = 1'b0;
    endtask

    task automatic rd(input logic [2:0] o, input logic [7:0] e, input string tag);
        rd_raw(win(o), e, tag);
    endtask

    task automatic wrb(input logic [2:0] o, input logic [7:0] d);
        cyc(1'b1, 1'b1, o, d, 1'b0);
    endtask

    task automatic tick1();
        cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'd0, 8'h00, 1'b0);
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y, input logic [7:0] ctl);
        wrb(3'd0, 8'h80);
        wrb(3'd1, s); wrb(3'd2, m); wrb(3'd3, h); wrb(3'd4, dw);
        wrb(3'd5, dt); wrb(3'd6, mo); wrb(3'd7, y);
        wrb(3'd0, ctl);
    endtask

    task automatic chk_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y, input string tag);
        rd(3'd1, s, {tag, " sec"});   rd(3'd2, m, {tag, " min"});
        rd(3'd3, h, {tag, " hour"});  rd(3'd4, dw, {tag, " dow"});
        rd(3'd5, dt, {tag, " date"}); rd(3'd6, mo, {tag, " month"});
        rd(3'd7, y, {tag, " year"});
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, R2 offset order
        rd(3'd0, 8'h00, "R1 ctrl");
        chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 R2 reset");

        // R2 outside the window
        rd_raw(15'h1234, 8'h00, "R2 outside rdata");
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = 15'h7FF0;
        #2;
        checks++;
        if (hit !== 1'b0) begin fails++; $display("FAIL R2 hit: actual %b expected 0", hit); end
        addr = 15'h7FFB;
        #1;
        checks++;
        if (hit !== 1'b1) begin fails++; $display("FAIL R2 hit: actual %b expected 1", hit); end
        @(posedge clk); #1 sel = 1'b0;

        // R3 single step with refresh
        tick1();
        rd(3'd1, 8'h01, "R3 first step");

        // R10 control readback, R7 stored and masked writes
        wrb(3'd0, 8'h9F);
        rd(3'd0, 8'h9F, "R10 ctrl readback");
        wrb(3'd1, 8'h58); wrb(3'd2, 8'h59); wrb(3'd3, 8'hFF);
        rd(3'd3, 8'h3F, "R7 hour mask");
        wrb(3'd3, 8'h23); wrb(3'd4, 8'h07); wrb(3'd5, 8'h28); wrb(3'd6, 8'h02); wrb(3'd7, 8'h23);
        rd(3'd1, 8'h58, "R7 stored sec");
        tick1();
        rd(3'd1, 8'h58, "R7 no refresh");
        wrb(3'd0, 8'h00);
        rd(3'd0, 8'h00, "R10 ctrl cleared");
        rd(3'd1, 8'h58, "R8 after commit");

        // R8 counting resumes, R3/R4/R5 full rollover, non-leap February
        tick1();
        rd(3'd1, 8'h59, "R8 resume");
        tick1();
        chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h23, "R4 R5 feb28");

        // R5 leap February
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h00);
        tick1();
        chk_time(8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24, "R5 leap 29");
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24, 8'h00);
        tick1();
        rd(3'd5, 8'h01, "R5 leap end date");
        rd(3'd6, 8'h03, "R5 leap end month");

        // R5 30-day month
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h99, 8'h00);
        tick1();
        rd(3'd5, 8'h01, "R5 april date");
        rd(3'd6, 8'h05, "R5 april month");

        // R4 weekday wrap, R5 31-day month
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h30, 8'h01, 8'h00, 8'h00);
        tick1();
        rd(3'd4, 8'h01, "R4 dow wrap");
        rd(3'd5, 8'h31, "R5 january 31");

        // R4 year wrap
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h00);
        tick1();
        chk_time(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00, "R4 year wrap");

        // R9 tick in the commit cycle
        wrb(3'd0, 8'h80);
        wrb(3'd1, 8'h10);
        cyc(1'b1, 1'b1, 3'd0, 8'h00, 1'b1);
        rd(3'd1, 8'h10, "R9 tick dropped");
        tick1();
        rd(3'd1, 8'h11, "R9 next tick");

        // R7 ignored write
        wrb(3'd1, 8'h45);
        rd(3'd1, 8'h11, "R7 write ignored");

        // R6 hold
        wrb(3'd0, 8'h40);
        tick1(); tick1(); tick1();
        rd(3'd1, 8'h11, "R6 frozen sec");
        rd(3'd2, 8'h00, "R6 frozen min");
        wrb(3'd0, 8'h00);
        rd(3'd1, 8'h11, "R6 release no tick");
        tick1();
        rd(3'd1, 8'h15, "R6 counters ran");

        // R11 drop three ticks after the wrap
        set_time(8'h58, 8'h10, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30, 8'h03);
        rd(3'd0, 8'h03, "R10 trim ctrl");
        tick1();
        tick1();
        rd(3'd1, 8'h00, "R11 wrap");
        tick1(); tick1(); tick1();
        rd(3'd1, 8'h00, "R11 dropped");
        tick1();
        rd(3'd1, 8'h01, "R11 resumed");
        rd(3'd2, 8'h11, "R11 minute");

        // R12 add two steps after the wrap
        set_time(8'h58, 8'h20, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30, 8'h22);
        tick1();
        rd(3'd1, 8'h59, "R12 before wrap");
        tick1();
        idle(4);
        rd(3'd1, 8'h02, "R12 extra steps");
        idle(3);
        rd(3'd1, 8'h02, "R12 budget spent");
        tick1();
        rd(3'd1, 8'h03, "R12 normal tick");
        rd(3'd2, 8'h21, "R12 minute");

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule